// File: doc/BRIEF.md
# Cache line merge buffer

The merge buffer sits beside the lookup pipe of a write-allocate cache and keeps one tracking slot per outstanding line miss. When a request misses the cache, the line takes a free slot and a fetch goes out to far memory. Until that line comes back, later writes to it are folded into the same slot, byte by byte. Reads are answered directly from the slot when the whole word they want has already been written.

When the fill data returns, it is laid under the buffered bytes, and the merged line waits to be handed to the cache pipe. This one path serves write misses and read misses alike. A read that cannot be served from buffered bytes stalls the core. Its word travels with the merged line through a three-stage lookup pipe and comes out as the read response at the last stage. A slot is released when the pipe takes its line; from then on the line lives in the cache.

Requests are assumed to arrive only after they have missed the cache arrays. Tags, ways and replacement are handled outside.

Top module: `cl_merge_buffer`

## Requirements
- R1: During and right after reset no slot is in use, and stall_o, rsp_valid_o, pipe_fill_valid_o and mem_req_valid_o are all low.
- R2: A request to a line held by no slot takes the lowest-numbered free slot. In that same cycle it raises mem_req_valid_o, with mem_req_id_o set to the slot number and mem_req_line_o set to the line.
- R3: A request to a line already held by a slot never takes another slot and raises no mem_req_valid_o. No two slots ever hold the same line.
- R4: In the merged line, each byte written since the slot was taken keeps its latest written value, and every other byte takes the fill data. Word k sits in bits [k*WORD_W +: WORD_W]. Bit j of req_be_i enables byte j of the addressed word, which is bits [j*8 +: 8].
- R5: A read to a held line whose addressed word has all byte enables set does not stall. rsp_valid_o rises the next cycle, carrying the buffered word.
- R6: A read to a held line whose word is not fully written raises stall_o from the next cycle. Its response comes from the lookup pipe: rsp_valid_o is high exactly three cycles after the cycle in which the pipe accepts that line, and it carries the merged word.
- R7: A read to a line held by no slot takes a slot, requests the fill and stalls. It is answered through the pipe in the same way as R6.
- R8: A slot offers its merged line on pipe_fill_valid_o from the cycle after its fill arrives, and pipe_fill_rd_o is set when a read waits on it. When several lines are ready, the lowest-numbered slot is offered first, and the offer holds until pipe_fill_ready_i is high.
- R9: A slot is free in the cycle after the pipe accepts its line.
- R10: When every slot is in use, a request to an untracked line raises stall_o and no mem_req_valid_o. Writes to lines already held are still taken.
- R11: A request to the line whose slot the pipe accepts in that same cycle is held off with stall_o.
- R12: stall_o stays high through the response cycle of a stalled read and drops in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_line_i | input | LINE_W | Line address |
| req_word_i | input | log2(WORDS) | Word within the line |
| req_data_i | input | WORD_W | Write data |
| req_be_i | input | WORD_W/8 | Byte enables of the write |
| stall_o | output | 1 | Request not taken / core must stall |
| mem_req_valid_o | output | 1 | Fetch request to far memory |
| mem_req_id_o | output | log2(N_ENT) | Slot that the fetch belongs to |
| mem_req_line_o | output | LINE_W | Line to fetch |
| fill_valid_i | input | 1 | Fill data returning |
| fill_id_i | input | log2(N_ENT) | Slot the fill belongs to |
| fill_data_i | input | WORDS*WORD_W | Fill line |
| pipe_fill_valid_o | output | 1 | Merged line offered to the cache pipe |
| pipe_fill_ready_i | input | 1 | Pipe accepts the offered line |
| pipe_fill_line_o | output | LINE_W | Line address of the offered line |
| pipe_fill_data_o | output | WORDS*WORD_W | Merged line data |
| pipe_fill_rd_o | output | 1 | A stalled read waits on this line |
| rsp_valid_o | output | 1 | Read response |
| rsp_data_o | output | WORD_W | Read response data |

## Verification
The bench builds the block with its defaults: four slots, four 32-bit words per line and 8-bit line addresses. With four-byte words, all 16 byte-enable patterns fit into one sweep, each followed by a complementary write and a fill, so every mix of buffered and filled bytes is compared against an arithmetic merge. Four slots are few enough that the bench can fill every one of them. That lets it reach the stall on a full buffer, the choice between two ready lines, the handoff collision and the reuse of a slot in the cycle after it is freed.

// File: rtl/mb_pkg.sv
package mb_pkg;
  typedef enum logic [1:0] {
    ENT_IDLE = 2'd0,
    ENT_WAIT = 2'd1,
    ENT_FULL = 2'd2
  } ent_st_e;
endpackage

// File: rtl/mb_first_one.sv
module mb_first_one #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic found;
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
        found    = 1'b1;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/mb_entry.sv
module mb_entry
  import mb_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int LINE_W = 8,
  localparam int WB = WORD_W / 8,
  localparam int LB = WORDS * WB,
  localparam int LD = WORDS * WORD_W,
  localparam int WI = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              wr_i,
  input  logic [WI-1:0]     word_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WB-1:0]     wbe_i,
  input  logic              rd_mark_i,
  input  logic              fill_i,
  input  logic [LD-1:0]     fill_data_i,
  input  logic              release_i,
  output logic              valid_o,
  output logic              filled_o,
  output logic [LINE_W-1:0] line_o,
  output logic [LD-1:0]     data_o,
  output logic [LB-1:0]     be_o,
  output logic              rd_o,
  output logic [WI-1:0]     rd_word_o
);
  ent_st_e           st_q;
  logic [LINE_W-1:0] line_q;
  logic [LD-1:0]     data_q, data_n;
  logic [LB-1:0]     be_q, be_n;
  logic              rd_q;
  logic [WI-1:0]     rd_word_q;

  // fill lands first, a same-cycle write lands on top of it
  always_comb begin
    data_n = data_q;
    be_n   = alloc_i ? '0 : be_q;
    if (fill_i) begin
      for (int b = 0; b < LB; b++)
        if (!be_q[b]) data_n[b*8 +: 8] = fill_data_i[b*8 +: 8];
      be_n = '1;
    end
    if (wr_i) begin
      for (int b = 0; b < WB; b++) begin
        if (wbe_i[b]) begin
          data_n[int'(word_i)*WORD_W + b*8 +: 8] = wdata_i[b*8 +: 8];
          be_n[int'(word_i)*WB + b]              = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ENT_IDLE;
      line_q    <= '0;
      data_q    <= '0;
      be_q      <= '0;
      rd_q      <= 1'b0;
      rd_word_q <= '0;
    end else begin
      if (release_i)    st_q <= ENT_IDLE;
      else if (alloc_i) st_q <= ENT_WAIT;
      else if (fill_i)  st_q <= ENT_FULL;
      if (alloc_i) line_q <= line_i;
      data_q <= data_n;
      be_q   <= be_n;
      rd_q   <= release_i ? 1'b0 : (rd_q | rd_mark_i);
      if (rd_mark_i) rd_word_q <= word_i;
    end
  end

  assign valid_o   = (st_q != ENT_IDLE);
  assign filled_o  = (st_q == ENT_FULL);
  assign line_o    = line_q;
  assign data_o    = data_q;
  assign be_o      = be_q;
  assign rd_o      = rd_q;
  assign rd_word_o = rd_word_q;

  p_alloc_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (st_q == ENT_IDLE));
  p_fill_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> (st_q == ENT_WAIT));
  p_full_bytes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ENT_FULL) |-> (&be_q));
endmodule

// File: rtl/mb_fill_pipe.sv
module mb_fill_pipe #(
  parameter int DEPTH = 3,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_rd_i,
  input  logic [DW-1:0] in_data_i,
  output logic          out_rd_o,
  output logic [DW-1:0] out_data_o
);
  logic          rd_q [DEPTH];
  logic [DW-1:0] d_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stg
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rd_q[g] <= 1'b0;
          d_q[g]  <= '0;
        end else begin
          rd_q[g] <= in_valid_i & in_rd_i;
          d_q[g]  <= in_data_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rd_q[g] <= 1'b0;
          d_q[g]  <= '0;
        end else begin
          rd_q[g] <= rd_q[g-1];
          d_q[g]  <= d_q[g-1];
        end
      end
    end
  end

  assign out_rd_o   = rd_q[DEPTH-1];
  assign out_data_o = d_q[DEPTH-1];
endmodule

// File: rtl/cl_merge_buffer.sv
module cl_merge_buffer #(
  parameter int N_ENT  = 4,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int LINE_W = 8,
  parameter int PIPE_D = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic                       req_write_i,
  input  logic [LINE_W-1:0]          req_line_i,
  input  logic [$clog2(WORDS)-1:0]   req_word_i,
  input  logic [WORD_W-1:0]          req_data_i,
  input  logic [WORD_W/8-1:0]        req_be_i,
  output logic                       stall_o,
  output logic                       mem_req_valid_o,
  output logic [$clog2(N_ENT)-1:0]   mem_req_id_o,
  output logic [LINE_W-1:0]          mem_req_line_o,
  input  logic                       fill_valid_i,
  input  logic [$clog2(N_ENT)-1:0]   fill_id_i,
  input  logic [WORDS*WORD_W-1:0]    fill_data_i,
  output logic                       pipe_fill_valid_o,
  input  logic                       pipe_fill_ready_i,
  output logic [LINE_W-1:0]          pipe_fill_line_o,
  output logic [WORDS*WORD_W-1:0]    pipe_fill_data_o,
  output logic                       pipe_fill_rd_o,
  output logic                       rsp_valid_o,
  output logic [WORD_W-1:0]          rsp_data_o
);
  localparam int WB = WORD_W / 8;
  localparam int LB = WORDS * WB;
  localparam int LD = WORDS * WORD_W;
  localparam int WI = $clog2(WORDS);
  localparam int EI = $clog2(N_ENT);

  logic [N_ENT-1:0]  ent_valid, ent_filled, ent_rd;
  logic [LINE_W-1:0] ent_line  [N_ENT];
  logic [LD-1:0]     ent_data  [N_ENT];
  logic [LB-1:0]     ent_be    [N_ENT];
  logic [WI-1:0]     ent_rdw   [N_ENT];

  logic [N_ENT-1:0] hit_oh, alloc_oh, out_oh, tgt_oh;
  logic [EI-1:0]    hit_idx, alloc_idx, out_idx;
  logic             hit_any, free_any, out_any;

  always_comb begin
    for (int i = 0; i < N_ENT; i++)
      hit_oh[i] = ent_valid[i] && (ent_line[i] == req_line_i);
  end

  mb_first_one #(.N(N_ENT)) u_hit (
    .req_i(hit_oh), .gnt_o(), .idx_o(hit_idx), .any_o(hit_any));
  mb_first_one #(.N(N_ENT)) u_free (
    .req_i(~ent_valid), .gnt_o(alloc_oh), .idx_o(alloc_idx), .any_o(free_any));
  mb_first_one #(.N(N_ENT)) u_out (
    .req_i(ent_filled), .gnt_o(out_oh), .idx_o(out_idx), .any_o(out_any));

  logic [WB-1:0]     hit_be;
  logic [WORD_W-1:0] hit_word;
  logic              word_full;
  assign hit_be    = ent_be[hit_idx][req_word_i*WB +: WB];
  assign hit_word  = ent_data[hit_idx][req_word_i*WORD_W +: WORD_W];
  assign word_full = &hit_be;

  logic handoff, conflict, acc, new_alloc, direct, mark, rd_wait_q;
  assign handoff   = out_any & pipe_fill_ready_i;
  assign conflict  = req_valid_i & (|(hit_oh & out_oh)) & pipe_fill_ready_i;
  assign stall_o   = rd_wait_q | (req_valid_i & ~hit_any & ~free_any) | conflict;
  assign acc       = req_valid_i & ~stall_o;
  assign new_alloc = acc & ~hit_any;
  assign tgt_oh    = hit_any ? hit_oh : alloc_oh;
  assign direct    = acc & ~req_write_i & hit_any & word_full;
  assign mark      = acc & ~req_write_i & ~(hit_any & word_full);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    mb_entry #(.WORDS(WORDS), .WORD_W(WORD_W), .LINE_W(LINE_W)) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (new_alloc & alloc_oh[g]),
      .line_i     (req_line_i),
      .wr_i       (acc & req_write_i & tgt_oh[g]),
      .word_i     (req_word_i),
      .wdata_i    (req_data_i),
      .wbe_i      (req_be_i),
      .rd_mark_i  (mark & tgt_oh[g]),
      .fill_i     (fill_valid_i && (fill_id_i == EI'(g))),
      .fill_data_i(fill_data_i),
      .release_i  (handoff & out_oh[g]),
      .valid_o    (ent_valid[g]),
      .filled_o   (ent_filled[g]),
      .line_o     (ent_line[g]),
      .data_o     (ent_data[g]),
      .be_o       (ent_be[g]),
      .rd_o       (ent_rd[g]),
      .rd_word_o  (ent_rdw[g])
    );
  end

  assign mem_req_valid_o   = new_alloc;
  assign mem_req_id_o      = alloc_idx;
  assign mem_req_line_o    = req_line_i;
  assign pipe_fill_valid_o = out_any;
  assign pipe_fill_line_o  = ent_line[out_idx];
  assign pipe_fill_data_o  = ent_data[out_idx];
  assign pipe_fill_rd_o    = out_any & ent_rd[out_idx];

  logic [WORD_W-1:0] out_word, q3_data;
  logic              q3_rd;
  assign out_word = ent_data[out_idx][ent_rdw[out_idx]*WORD_W +: WORD_W];

  mb_fill_pipe #(.DEPTH(PIPE_D), .DW(WORD_W)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(handoff),
    .in_rd_i   (pipe_fill_rd_o),
    .in_data_i (out_word),
    .out_rd_o  (q3_rd),
    .out_data_o(q3_data)
  );

  logic              dir_v_q;
  logic [WORD_W-1:0] dir_d_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_wait_q <= 1'b0;
      dir_v_q   <= 1'b0;
      dir_d_q   <= '0;
    end else begin
      if (q3_rd)     rd_wait_q <= 1'b0;
      else if (mark) rd_wait_q <= 1'b1;
      dir_v_q <= direct;
      if (direct) dir_d_q <= hit_word;
    end
  end

  assign rsp_valid_o = dir_v_q | q3_rd;
  assign rsp_data_o  = q3_rd ? q3_data : dir_d_q;

  p_one_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_oh));
  p_rsp_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dir_v_q && q3_rd));
  p_mark_stalls_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark |=> stall_o);
  p_offer_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_fill_valid_o && !pipe_fill_ready_i) |=> pipe_fill_valid_o);
  p_slot_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handoff |=> ((ent_valid & $past(out_oh)) == '0));
  p_full_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit_any && !free_any) |-> (stall_o && !mem_req_valid_o));
  p_stall_drop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q3_rd |=> !stall_o);
endmodule

// File: tb/tb_cl_merge_buffer.sv
module tb_cl_merge_buffer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]   req_line = '0;
  logic [1:0]   req_word = '0;
  logic [31:0]  req_data = '0;
  logic [3:0]   req_be = '0;
  logic         stall, mem_req_valid;
  logic [1:0]   mem_req_id;
  logic [7:0]   mem_req_line;
  logic         fill_valid = 1'b0;
  logic [1:0]   fill_id = '0;
  logic [127:0] fill_data = '0;
  logic         pipe_valid, pipe_ready = 1'b0, pipe_rd;
  logic [7:0]   pipe_line;
  logic [127:0] pipe_data;
  logic         rsp_valid;
  logic [31:0]  rsp_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cl_merge_buffer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_line_i(req_line),
    .req_word_i(req_word), .req_data_i(req_data), .req_be_i(req_be),
    .stall_o(stall), .mem_req_valid_o(mem_req_valid), .mem_req_id_o(mem_req_id),
    .mem_req_line_o(mem_req_line), .fill_valid_i(fill_valid), .fill_id_i(fill_id),
    .fill_data_i(fill_data), .pipe_fill_valid_o(pipe_valid),
    .pipe_fill_ready_i(pipe_ready), .pipe_fill_line_o(pipe_line),
    .pipe_fill_data_o(pipe_data), .pipe_fill_rd_o(pipe_rd),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(input bit wr, input logic [7:0] line, input logic [1:0] word,
                       input logic [31:0] data, input logic [3:0] be);
    req_valid = 1'b1; req_write = wr; req_line = line;
    req_word = word; req_data = data; req_be = be;
    #1;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; req_be = '0;
  endtask

  task automatic do_reset();
    idle();
    fill_valid = 1'b0; pipe_ready = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(!stall && !rsp_valid && !pipe_valid && !mem_req_valid, "R1 outputs in reset",
        {stall, rsp_valid, pipe_valid, mem_req_valid}, 0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic give_fill(input logic [1:0] id, input logic [127:0] d);
    fill_valid = 1'b1; fill_id = id; fill_data = d;
    tick();
    fill_valid = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]   mb [16];
    logic         mbe [16];
    logic [127:0] fl, ex;
    logic [31:0]  d1, d2;
    logic [3:0]   be2;
    logic [7:0]   ln;

    do_reset();
    chk(!stall && !pipe_valid && !rsp_valid, "R1 after reset", {stall, pipe_valid}, 0);

    // byte-enable sweep: write, complementary write, fill, merged line check
    for (int p = 0; p < 16; p++) begin
      for (int b = 0; b < 16; b++) begin mb[b] = 8'h00; mbe[b] = 1'b0; end
      ln  = 8'(16 + p);
      d1  = 32'h11223344 ^ (32'(p) * 32'h01010101);
      d2  = 32'h99AABBCC + 32'(p);
      be2 = ~4'(p);
      fl  = {32'hF3F3F300 + 32'(p), 32'hE2E2E200 + 32'(p),
             32'hD1D1D100 + 32'(p), 32'hC0C0C000 + 32'(p)};
      drive(1'b1, ln, 2'(p % 4), d1, 4'(p));
      chk(!stall && mem_req_valid, "R2 miss raises fetch", {stall, mem_req_valid}, 1);
      chk(mem_req_id == 2'd0 && mem_req_line == ln, "R2 fetch id and line",
          {mem_req_id, mem_req_line}, {2'd0, ln});
      for (int k = 0; k < 4; k++)
        if (p[k]) begin mb[(p % 4)*4 + k] = d1[k*8 +: 8]; mbe[(p % 4)*4 + k] = 1'b1; end
      tick();
      drive(1'b1, ln, 2'((p + 1) % 4), d2, be2);
      chk(!stall && !mem_req_valid, "R3 second write to line reuses slot",
          {stall, mem_req_valid}, 0);
      for (int k = 0; k < 4; k++)
        if (be2[k]) begin
          mb[((p + 1) % 4)*4 + k] = d2[k*8 +: 8]; mbe[((p + 1) % 4)*4 + k] = 1'b1;
        end
      tick();
      idle();
      #1;
      chk(!pipe_valid, "R8 no offer before fill", pipe_valid, 0);
      give_fill(2'd0, fl);
      for (int b = 0; b < 16; b++) ex[b*8 +: 8] = mbe[b] ? mb[b] : fl[b*8 +: 8];
      chk(pipe_valid && !pipe_rd && pipe_line == ln, "R8 merged line offered",
          {pipe_valid, pipe_rd, pipe_line}, {1'b1, 1'b0, ln});
      chk(pipe_data == ex, "R4 merged bytes", pipe_data, ex);
      pipe_ready = 1'b1;
      tick();
      pipe_ready = 1'b0;
      #1;
      chk(!pipe_valid, "R9 slot released after accept", pipe_valid, 0);
    end

    // direct read hit and word-miss read through the pipe
    do_reset();
    drive(1'b1, 8'h40, 2'd2, 32'hCAFEF00D, 4'hF); tick();
    drive(1'b1, 8'h40, 2'd0, 32'h12345678, 4'h3); tick();
    drive(1'b0, 8'h40, 2'd2, 32'h0, 4'h0);
    chk(!stall && !mem_req_valid, "R5 full word read not stalled", {stall, mem_req_valid}, 0);
    tick();
    idle();
    #1;
    chk(rsp_valid && rsp_data == 32'hCAFEF00D, "R5 response from buffer",
        {rsp_valid, rsp_data}, {1'b1, 32'hCAFEF00D});
    drive(1'b0, 8'h40, 2'd0, 32'h0, 4'h0);
    chk(!stall, "R6 partial word read accepted", stall, 0);
    tick();
    idle();
    #1;
    chk(stall && !rsp_valid, "R6 stall after word miss", {stall, rsp_valid}, 2'b10);
    tick(); tick();
    chk(stall && !pipe_valid, "R6 stall holds until fill", {stall, pipe_valid}, 2'b10);
    fl = {32'hA3A3A3A3, 32'hA2A2A2A2, 32'hA1A1A1A1, 32'hA0B0C0D0};
    give_fill(2'd0, fl);
    chk(pipe_valid && pipe_rd, "R8 read indication on offer", {pipe_valid, pipe_rd}, 2'b11);
    pipe_ready = 1'b1;
    tick();
    pipe_ready = 1'b0;
    #1;
    chk(!rsp_valid, "R6 no response one cycle after accept", rsp_valid, 0);
    tick();
    chk(!rsp_valid, "R6 no response two cycles after accept", rsp_valid, 0);
    tick();
    chk(rsp_valid && rsp_data == 32'hA0B05678, "R6 merged word in q3",
        {rsp_valid, rsp_data}, {1'b1, 32'hA0B05678});
    chk(stall, "R12 stall during response cycle", stall, 1);
    tick();
    chk(!stall && !rsp_valid, "R12 stall drops after response", {stall, rsp_valid}, 0);

    // read miss to an untracked line
    do_reset();
    drive(1'b0, 8'h55, 2'd3, 32'h0, 4'h0);
    chk(!stall && mem_req_valid && mem_req_line == 8'h55, "R7 read miss fetch",
        {stall, mem_req_valid, mem_req_line}, {2'b01, 8'h55});
    tick();
    idle();
    #1;
    chk(stall, "R7 read miss stalls", stall, 1);
    fl = {32'h7E7E7E7E, 32'h6D6D6D6D, 32'h5C5C5C5C, 32'h4B4B4B4B};
    give_fill(2'd0, fl);
    chk(pipe_valid && pipe_rd && pipe_line == 8'h55, "R7 line offered with read",
        {pipe_valid, pipe_rd, pipe_line}, {2'b11, 8'h55});
    pipe_ready = 1'b1;
    tick();
    pipe_ready = 1'b0;
    tick(); tick();
    chk(rsp_valid && rsp_data == 32'h7E7E7E7E, "R7 response after fill",
        {rsp_valid, rsp_data}, {1'b1, 32'h7E7E7E7E});

    // full buffer, priority, collision, reuse
    do_reset();
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 8'(100 + i), 2'd0, 32'(i), 4'h1);
      chk(mem_req_valid && mem_req_id == 2'(i), "R2 lowest free slot taken",
          {mem_req_valid, mem_req_id}, {1'b1, 2'(i)});
      tick();
    end
    drive(1'b1, 8'd104, 2'd0, 32'h5, 4'h1);
    chk(stall && !mem_req_valid, "R10 miss on full buffer stalls", {stall, mem_req_valid}, 2'b10);
    tick();
    drive(1'b1, 8'd101, 2'd1, 32'hFFFF0000, 4'hF);
    chk(!stall && !mem_req_valid, "R10 write to held line taken when full",
        {stall, mem_req_valid}, 0);
    tick();
    idle();
    give_fill(2'd2, '0);
    chk(pipe_valid && pipe_line == 8'd102, "R8 single ready line offered", pipe_line, 8'd102);
    give_fill(2'd0, '0);
    chk(pipe_valid && pipe_line == 8'd100, "R8 lowest slot offered first", pipe_line, 8'd100);
    tick();
    chk(pipe_valid && pipe_line == 8'd100, "R8 offer held without ready", pipe_line, 8'd100);
    pipe_ready = 1'b1;
    drive(1'b1, 8'd100, 2'd1, 32'h1, 4'h1);
    chk(stall && !mem_req_valid, "R11 request to line being handed off stalls",
        {stall, mem_req_valid}, 2'b10);
    tick();
    pipe_ready = 1'b0;
    drive(1'b1, 8'd104, 2'd0, 32'h7, 4'h1);
    chk(!stall && mem_req_valid && mem_req_id == 2'd0, "R9 freed slot reused next cycle",
        {stall, mem_req_valid, mem_req_id}, {2'b01, 2'd0});
    chk(pipe_valid && pipe_line == 8'd102, "R8 next ready line offered", pipe_line, 8'd102);
    tick();
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule